// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

This block models one programmable cell of a logic fabric. A static configuration word selects its function. It can act as any Boolean function of three inputs, as a level-sensitive latch, as an edge-triggered D flip-flop, or as a D flip-flop with a clock enable. Before any input reaches the function it can be inverted by configuration. The storage modes carry an asynchronous clear or set. Configuration picks which of the two is used.

The cell has four data/control inputs and a clock. A synchronous reset clears the stored flip-flop value. The configuration word is held constant while the cell operates. The cell result appears on two outputs that carry the same value: one feeds local routing and the other feeds long routing.

Top module: `lcell_top`

## Requirements
- R1: While `rst` is high at a rising clock edge in either flip-flop mode, the stored value becomes 0, whatever the data input is.
- R2: `y_local` and `y_long` carry the same value at all times.
- R3: The configuration word holds these fields: `cfg[7:0]` is the truth table, `cfg[9:8]` is the mode (0 combinational, 1 latch, 2 flip-flop, 3 flip-flop with enable), `cfg[13:10]` is the inversion mask and `cfg[14]` is the force-one select. In combinational mode the output is `cfg[{v2,v1,v0}]`, where `vi` is input i after inversion, and `din[3]` has no effect.
- R4: Mask bit i inverts `din[i]` before use, for data and for control roles alike (`vi = din[i] ^ cfg[10+i]`).
- R5: In flip-flop mode the output takes `v0` at each rising clock edge, and `v2` has no effect.
- R6: In latch and flip-flop modes, `v1` high forces the output at once, with no clock edge needed, to 0 (`cfg[14]`=0) or to 1 (`cfg[14]`=1). This force overrides data and clock.
- R7: In enable flip-flop mode `v1` is the enable. A rising edge with `v1` low leaves the stored value unchanged, and a rising edge with `v1` high captures `v0`.
- R8: In enable flip-flop mode the clear/set control is `v3`. It acts at once and overrides the enable. Here `v1` high does not force the output.
- R9: In latch mode `clk` is the gate. The output follows `v0` while `clk` is high and holds while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flop modes; gate for latch mode |
| rst | input | 1 | Synchronous active-high reset of the stored flip-flop value |
| din | input | NUM_IN (4) | Data and control inputs of the cell |
| cfg | input | 2**LUT_IN+NUM_IN+3 (15) | Static configuration word |
| y_local | output | 1 | Cell result for local routing |
| y_long | output | 1 | Copy of the cell result for long routing |

## Verification
The bench uses the default parameters: four inputs and a three-input table. At this size all 256 truth tables can be swept against every input index in combinational mode. Because the table is small, every mode and control role can also be reached with a few directed steps. These steps place clear and set pulses between clock edges, hold them across edges, and send them through inverted inputs. They also test the enable against the control on the fourth input, and the transparent and opaque phases of the latch.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_LATCH = 2'd1,
    MODE_DFF   = 2'd2,
    MODE_EDFF  = 2'd3
  } cell_mode_e;

  localparam int MODE_W = 2;

endpackage

// File: rtl/lcell_polarity.sv
module lcell_polarity #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] raw,
  input  logic [WIDTH-1:0] flip,
  output logic [WIDTH-1:0] eff
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign eff[i] = raw[i] ^ flip[i];
  end

endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int K = 3
) (
  input  logic [(1<<K)-1:0] truth,
  input  logic [K-1:0]      sel,
  output logic              y
);

  localparam int LEAVES = 1 << K;

  // Binary mux tree: stage s halves the candidates using sel[s].
  logic [LEAVES-1:0] stage [K+1];

  assign stage[0] = truth;

  for (genvar s = 0; s < K; s++) begin : g_stage
    localparam int CNT = LEAVES >> (s + 1);
    for (genvar j = 0; j < CNT; j++) begin : g_node
      assign stage[s+1][j] = sel[s] ? stage[s][2*j+1] : stage[s][2*j];
    end
    assign stage[s+1][LEAVES-1:CNT] = '0;
  end

  assign y = stage[K][0];

endmodule

// File: rtl/lcell_store.sv
module lcell_store (
  input  logic clk,
  input  logic rst,
  input  logic is_latch,
  input  logic is_flop,
  input  logic d,
  input  logic en,
  input  logic force_req,
  input  logic force_val,
  output logic q
);

  logic latch_force;
  logic flop_force;
  logic lat_q;
  logic ff_q;

  assign latch_force = is_latch & force_req;
  assign flop_force  = is_flop & force_req;

  // Level-sensitive element; clk is the gate.
  always_latch begin
    if (latch_force)
      lat_q <= force_val;
    else if (clk)
      lat_q <= d;
  end

  // Edge element with asynchronous force, synchronous reset and enable.
  always_ff @(posedge clk or posedge flop_force) begin
    if (flop_force)
      ff_q <= force_val;
    else if (rst)
      ff_q <= 1'b0;
    else if (en)
      ff_q <= d;
  end

  assign q = is_latch ? lat_q : ff_q;

endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int LUT_IN = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_IN-1:0]                      din,
  input  logic [(1<<LUT_IN)+NUM_IN+MODE_W:0]     cfg,
  output logic                                   y_local,
  output logic                                   y_long
);

  localparam int LUT_SIZE = 1 << LUT_IN;
  localparam int MODE_LO  = LUT_SIZE;
  localparam int INV_LO   = MODE_LO + MODE_W;
  localparam int FORCE_B  = INV_LO + NUM_IN;
  localparam int PIN_DATA = 0;
  localparam int PIN_CTL  = 1;
  localparam int PIN_AUX  = NUM_IN - 1;

  logic [LUT_SIZE-1:0] truth;
  cell_mode_e          mode;
  logic [NUM_IN-1:0]   inv_mask;
  logic                force_one;
  logic [NUM_IN-1:0]   v;
  logic                lut_y;
  logic                store_q;
  logic                force_req;
  logic                enable;
  logic                result;

  assign truth     = cfg[LUT_SIZE-1:0];
  assign mode      = cell_mode_e'(cfg[INV_LO-1:MODE_LO]);
  assign inv_mask  = cfg[FORCE_B-1:INV_LO];
  assign force_one = cfg[FORCE_B];

  lcell_polarity #(.WIDTH(NUM_IN)) u_pol (
    .raw  (din),
    .flip (inv_mask),
    .eff  (v)
  );

  lcell_lut #(.K(LUT_IN)) u_lut (
    .truth (truth),
    .sel   (v[LUT_IN-1:0]),
    .y     (lut_y)
  );

  // Steer control roles per mode.
  always_comb begin
    force_req = 1'b0;
    enable    = 1'b1;
    unique case (mode)
      MODE_LATCH, MODE_DFF: force_req = v[PIN_CTL];
      MODE_EDFF: begin
        force_req = v[PIN_AUX];
        enable    = v[PIN_CTL];
      end
      default: force_req = 1'b0;
    endcase
  end

  lcell_store u_store (
    .clk       (clk),
    .rst       (rst),
    .is_latch  (mode == MODE_LATCH),
    .is_flop   ((mode == MODE_DFF) || (mode == MODE_EDFF)),
    .d         (v[PIN_DATA]),
    .en        (enable),
    .force_req (force_req),
    .force_val (force_one),
    .q         (store_q)
  );

  assign result  = (mode == MODE_COMB) ? lut_y : store_q;
  assign y_local = result;
  assign y_long  = result;

endmodule

// File: rtl/lcell_chk.sv
module lcell_chk
  import lcell_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int LUT_IN = 3
) (
  input logic                               clk,
  input logic                               rst,
  input logic [NUM_IN-1:0]                  din,
  input logic [(1<<LUT_IN)+NUM_IN+MODE_W:0] cfg,
  input logic                               y_local,
  input logic                               y_long
);

  localparam int LUT_SIZE = 1 << LUT_IN;
  localparam int INV_LO   = LUT_SIZE + MODE_W;
  localparam int FORCE_B  = INV_LO + NUM_IN;

  logic [NUM_IN-1:0] vv;
  logic [1:0]        md;
  logic              fill;
  logic              ctl_on;

  assign vv     = din ^ cfg[FORCE_B-1:INV_LO];
  assign md     = cfg[INV_LO-1:LUT_SIZE];
  assign fill   = cfg[FORCE_B];
  assign ctl_on = (md == 2'd3) ? vv[NUM_IN-1] : vv[1];

  a_r2_twin_outputs: assert property (@(posedge clk) disable iff (rst)
    y_local == y_long);

  a_r3_comb_lookup: assert property (@(posedge clk) disable iff (rst)
    (md == 2'd0) |-> (y_local == cfg[vv[LUT_IN-1:0]]));

  a_r6_force_overrides: assert property (@(posedge clk) disable iff (rst)
    (md != 2'd0 && ctl_on) |-> (y_local == fill));

  a_r5_flop_capture: assert property (@(posedge clk) disable iff (rst)
    (md == 2'd2 && !vv[1]) |=>
      (cfg != $past(cfg) || y_local == $past(vv[0]) || y_local == fill));

  a_r7_enable_hold: assert property (@(posedge clk) disable iff (rst)
    (md == 2'd3 && !vv[1] && !vv[NUM_IN-1]) |=>
      (cfg != $past(cfg) || y_local == $past(y_local) || y_local == fill));

endmodule

bind lcell_top lcell_chk #(.NUM_IN(NUM_IN), .LUT_IN(LUT_IN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .cfg     (cfg),
  .y_local (y_local),
  .y_long  (y_long)
);

// File: tb/tb_lcell_top.sv
module tb_lcell_top;

  localparam int CW = 15;

  typedef struct packed {
    logic [7:0] lut;
    logic [3:0] inv;
    logic [3:0] pins;
    logic       exp;
  } vec_t;

  // Inversion vectors in combinational mode: expected = lut[(pins^inv)[2:0]].
  localparam vec_t VECS [9] = '{
    '{8'h80, 4'h0, 4'h7, 1'b1},
    '{8'h80, 4'h7, 4'h0, 1'b1},
    '{8'h80, 4'h1, 4'h7, 1'b0},
    '{8'h01, 4'h0, 4'h0, 1'b1},
    '{8'h01, 4'h7, 4'h7, 1'b1},
    '{8'h96, 4'h4, 4'h1, 1'b0},
    '{8'h96, 4'h0, 4'h4, 1'b1},
    '{8'hE8, 4'h8, 4'hB, 1'b1},
    '{8'hE8, 4'h2, 4'h3, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    din;
  logic [CW-1:0] cfg;
  logic          y_local;
  logic          y_long;
  int            nvec = 0;
  int            nfail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  lcell_top dut (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .cfg     (cfg),
    .y_local (y_local),
    .y_long  (y_long)
  );

  function automatic logic [CW-1:0] mk(input logic [7:0] t, input logic [1:0] m,
                                       input logic [3:0] inv, input logic f1);
    return {f1, inv, m, t};
  endfunction

  task automatic check(input string req, input logic exp);
    nvec++;
    if (y_local !== exp || y_long !== exp) begin
      nfail++;
      $display("FAIL %s: y_local=%b y_long=%b expected %b", req, y_local, y_long, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1;
    din = 4'b0001;
    cfg = mk(8'h00, 2'd2, 4'h0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset beats data", 1'b0);
    rst = 1'b0;

    // R3: every truth table against every index; din[3] toggled as noise
    for (int t = 0; t < 256; t++) begin
      for (int i = 0; i < 8; i++) begin
        cfg = mk(8'(t), 2'd0, 4'h0, 1'b0);
        din = {1'(i ^ t), 3'(i)};
        #1;
        check("R3 lookup", t[i]);
      end
    end

    // R4: table of inversion vectors
    for (int k = 0; k < 9; k++) begin
      cfg = mk(VECS[k].lut, 2'd0, VECS[k].inv, 1'b0);
      din = VECS[k].pins;
      #1;
      check("R4 inversion", VECS[k].exp);
    end

    // R5/R6 flip-flop mode
    @(negedge clk); cfg = mk(8'h00, 2'd2, 4'h0, 1'b0); din = 4'b0001;
    tick(); check("R5 capture 1", 1'b1);
    @(negedge clk); din = 4'b0000;
    tick(); check("R5 capture 0", 1'b0);
    @(negedge clk); din = 4'b0101;
    tick(); check("R5 v2 ignored", 1'b1);
    @(negedge clk); din = 4'b0011;
    #1; check("R6 async clear", 1'b0);
    tick(); check("R6 clear beats edge", 1'b0);
    @(negedge clk); din = 4'b0001;
    #1; check("R6 no edge yet", 1'b0);
    tick(); check("R5 recapture", 1'b1);
    @(negedge clk); rst = 1'b1;
    tick(); check("R1 sync reset", 1'b0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); cfg = mk(8'h00, 2'd2, 4'h0, 1'b1); din = 4'b0000;
    tick(); check("R5 capture 0 (set cfg)", 1'b0);
    @(negedge clk); din = 4'b0010;
    #1; check("R6 async set", 1'b1);
    tick(); check("R6 set holds", 1'b1);
    @(negedge clk); din = 4'b0000;
    tick(); check("R5 after set", 1'b0);
    @(negedge clk); cfg = mk(8'h00, 2'd2, 4'b0010, 1'b0); din = 4'b0001;
    #1; check("R4 inverted clear", 1'b0);
    @(negedge clk); din = 4'b0011;
    tick(); check("R4 inverted clear idle", 1'b1);

    // R7/R8 enable flip-flop mode
    @(negedge clk); cfg = mk(8'h00, 2'd3, 4'h0, 1'b0); din = 4'b0011;
    tick(); check("R8 v1 is not a clear", 1'b1);
    @(negedge clk); din = 4'b0000;
    tick(); check("R7 hold", 1'b1);
    @(negedge clk); din = 4'b0010;
    tick(); check("R7 enabled capture", 1'b0);
    @(negedge clk); din = 4'b0001;
    tick(); check("R7 hold 0", 1'b0);
    @(negedge clk); din = 4'b0011;
    tick(); check("R7 capture 1", 1'b1);
    @(negedge clk); din = 4'b1000;
    #1; check("R8 aux clear", 1'b0);
    tick(); check("R8 clear over edge", 1'b0);
    @(negedge clk); din = 4'b1011;
    tick(); check("R8 clear beats enable", 1'b0);
    @(negedge clk); din = 4'b0011;
    tick(); check("R7 release", 1'b1);
    @(negedge clk); cfg = mk(8'h00, 2'd3, 4'h0, 1'b1); din = 4'b0010;
    tick(); check("R7 capture 0 (set cfg)", 1'b0);
    @(negedge clk); din = 4'b1000;
    #1; check("R8 aux set", 1'b1);

    // R9 latch mode, clk is the gate
    @(negedge clk); cfg = mk(8'h00, 2'd1, 4'h0, 1'b0); din = 4'b0000;
    @(posedge clk); #2 din = 4'b0001;
    #1; check("R9 transparent 1", 1'b1);
    #1 din = 4'b0000;
    #1; check("R9 transparent 0", 1'b0);
    @(negedge clk); #1 din = 4'b0001;
    #1; check("R9 opaque hold", 1'b0);
    @(posedge clk); #1;
    check("R9 reopen", 1'b1);
    din = 4'b0011;
    #1; check("R6 latch clear", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule